// File: doc/BRIEF.md
# Bit-Plane Illumination Sequencer

This block paces a colour display built from a binary light modulator and a three-channel LED intensity DAC. The light source carries the weighting of each bit plane, so the modulator does not have to hold a plane for many frames. Each binary frame shows one bit plane. Its brightness comes from a single LED pulse whose DAC code is 2^s, where s is the bit position of that plane. A colour therefore takes only BITS binary frames. The three primaries follow one another to make one full-colour cycle.

The surrounding logic sends a `frame_tick` at each binary-frame boundary. It raises `frame_ready` once the modulator has taken the whole plane. The sequencer publishes the plane index and the colour that the pixel path must load. On an accepted ready it loads the DAC and waits a settling time for the mirrors. It then drives the LED enable for a fixed pulse width. Settle and pulse lengths are given in nanoseconds and converted to clock cycles from the clock frequency parameter. A start trigger marks the beginning of each full-colour cycle so that a camera can lock to it. Colours can be masked out with `color_en`.

Top module: `bitplane_illum_seq`

## Requirements
- R1: While reset is asserted and just after it is released, plane_idx is 0 and color_sel is red (code 0). led_on, dac_load, seq_start and err_overrun are 0, and all three DAC channels are 0.
- R2: Each frame_tick advances plane_idx by one at the next clock edge. After plane BITS-1 it wraps to 0 and moves to the next colour in the fixed order red (0), green (1), blue (2), then back to red. Without a tick, plane_idx and color_sel hold.
- R3: color_en bit i enables colour code i. When a colour finishes, disabled colours are skipped. If no colour is enabled, the colour simply rotates.
- R4: An accepted frame_ready produces a one-cycle dac_load at the next edge. At that same edge, the channel of the current colour takes 2^plane_idx and the other two channels take 0. These values are held until the next accepted ready.
- R5: led_on rises SETTLE_CYC clock cycles after the edge that sampled the accepted frame_ready. It stays high for exactly PULSE_CYC cycles. SETTLE_CYC is SETTLE_NS·(CLK_HZ/10^6)/1000, and PULSE_CYC is the same conversion applied to PULSE_NS.
- R6: A frame_ready is accepted at most once per binary frame, and only when the current colour is enabled. A rejected ready causes no dac_load, no change of DAC code and no LED pulse.
- R7: seq_start is a one-cycle pulse. It appears after the tick that moves the position to plane 0 of the lowest enabled colour (red when none is enabled).
- R8: A frame_tick that arrives during settle or pulse drops led_on at the same edge and sets err_overrun. err_overrun stays set until reset.
- R9: With all colours enabled, 3·BITS ticks bring the position back to red plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle binary-frame boundary |
| frame_ready | input | 1 | Plane fully loaded into the modulator |
| color_en | input | 3 | Per-colour enable, bit 0 red, 1 green, 2 blue |
| plane_idx | output | $clog2(BITS) | Bit position to show in the current frame |
| color_sel | output | 2 | Current colour, 0 red, 1 green, 2 blue |
| dac_r | output | BITS | Red DAC code |
| dac_g | output | BITS | Green DAC code |
| dac_b | output | BITS | Blue DAC code |
| dac_load | output | 1 | One-cycle strobe: DAC codes changed |
| led_on | output | 1 | LED pulse enable |
| seq_start | output | 1 | Full-colour cycle start trigger |
| err_overrun | output | 1 | Sticky: a frame boundary cut a pulse short |

## Verification
The bench runs a four-bit configuration through every plane of every colour. For each plane it works out the DAC weight, the settle delay and the pulse width by arithmetic, and compares the design against them. It checks the wrap from plane BITS-1. A design that wrapped one plane late or early would show the wrong colour, and its cycle would not close after 3·BITS ticks. It also checks masked colours: a sequencer that failed to skip them, or that still fired on a ready in a disabled colour, would pulse a dark colour or rewrite the DAC. A second ready in the same frame, a tick that arrives mid-pulse, and a trigger that moves when the lowest colour is masked are each driven at the ports. These catch double pulses, an LED that stays lit across a frame boundary, and a start trigger tied to red.

// File: rtl/bpis_pkg.sv
package bpis_pkg;

    localparam int NUM_COLORS  = 3;
    localparam int PLANE_W_MAX = 5;

    typedef enum logic [1:0] {
        CLR_R = 2'd0,
        CLR_G = 2'd1,
        CLR_B = 2'd2
    } color_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_PULSE
    } phase_e;

    typedef struct packed {
        color_e                 color;
        logic [PLANE_W_MAX-1:0] plane;
    } plane_pos_t;

    function automatic logic [1:0] rot_color(logic [1:0] c);
        return (c == 2'd2) ? 2'd0 : c + 2'd1;
    endfunction

    function automatic logic color_on(color_e c, logic [2:0] en);
        case (c)
            CLR_R:   return en[0];
            CLR_G:   return en[1];
            CLR_B:   return en[2];
            default: return 1'b0;
        endcase
    endfunction

    // next enabled colour after cur, searching cyclically; plain rotation if none
    function automatic color_e next_color(color_e cur, logic [2:0] en);
        logic [1:0] c;
        color_e     pick;
        logic       found;
        c     = cur;
        pick  = color_e'(rot_color(cur));
        found = 1'b0;
        for (int k = 0; k < NUM_COLORS; k++) begin
            c = rot_color(c);
            if (!found && color_on(color_e'(c), en)) begin
                pick  = color_e'(c);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    function automatic color_e first_color(logic [2:0] en);
        if (en[0]) return CLR_R;
        if (en[1]) return CLR_G;
        if (en[2]) return CLR_B;
        return CLR_R;
    endfunction

endpackage

// File: rtl/bpis_stepper.sv
module bpis_stepper
    import bpis_pkg::*;
#(
    parameter int BITS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_tick,
    input  logic [2:0] color_en,
    output plane_pos_t pos,
    output logic       seq_start
);
    localparam logic [PLANE_W_MAX-1:0] LAST = PLANE_W_MAX'(BITS - 1);

    plane_pos_t nxt;

    always_comb begin
        nxt = pos;
        if (pos.plane == LAST) begin
            nxt.plane = '0;
            nxt.color = next_color(pos.color, color_en);
        end else begin
            nxt.plane = pos.plane + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '{color: CLR_R, plane: '0};
            seq_start <= 1'b0;
        end else begin
            seq_start <= 1'b0;
            if (frame_tick) begin
                pos       <= nxt;
                seq_start <= (nxt.plane == '0) && (nxt.color == first_color(color_en));
            end
        end
    end
endmodule

// File: rtl/bpis_pulse_timer.sv
module bpis_pulse_timer
    import bpis_pkg::*;
#(
    parameter int SETTLE_CYC = 225,
    parameter int PULSE_CYC  = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic frame_ready,
    input  logic color_ok,
    output logic accept,
    output logic led_on,
    output logic err_overrun
);
    localparam int CMAX = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SETTLE_END = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] PULSE_END  = CW'(PULSE_CYC - 1);

    phase_e          ph;
    logic [CW-1:0]   cnt;
    logic            armed;

    assign accept = frame_ready && !frame_tick && armed && color_ok && (ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            cnt         <= '0;
            armed       <= 1'b1;
            led_on      <= 1'b0;
            err_overrun <= 1'b0;
        end else if (frame_tick) begin
            armed  <= 1'b1;
            led_on <= 1'b0;
            ph     <= PH_IDLE;
            cnt    <= '0;
            if (ph != PH_IDLE) err_overrun <= 1'b1;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        ph    <= PH_SETTLE;
                        cnt   <= '0;
                        armed <= 1'b0;
                    end
                end
                PH_SETTLE: begin
                    if (cnt == SETTLE_END) begin
                        ph     <= PH_PULSE;
                        cnt    <= '0;
                        led_on <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == PULSE_END) begin
                        ph     <= PH_IDLE;
                        cnt    <= '0;
                        led_on <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bpis_dac_map.sv
module bpis_dac_map
    import bpis_pkg::*;
#(
    parameter int BITS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  plane_pos_t       pos,
    output logic [BITS-1:0]  code_r,
    output logic [BITS-1:0]  code_g,
    output logic [BITS-1:0]  code_b,
    output logic             dac_load
);
    logic [BITS-1:0] weight;
    assign weight = BITS'(1) << pos.plane;

    for (genvar g = 0; g < NUM_COLORS; g++) begin : g_ch
        logic [BITS-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (load) q <= (pos.color == color_e'(2'(g))) ? weight : '0;
        end
    end

    assign code_r = g_ch[0].q;
    assign code_g = g_ch[1].q;
    assign code_b = g_ch[2].q;

    always_ff @(posedge clk) begin
        if (rst) dac_load <= 1'b0;
        else     dac_load <= load;
    end
endmodule

// File: rtl/bitplane_illum_seq.sv
module bitplane_illum_seq
    import bpis_pkg::*;
#(
    parameter int BITS      = 16,
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_NS = 4500,
    parameter int PULSE_NS  = 10000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_tick,
    input  logic                     frame_ready,
    input  logic [2:0]               color_en,
    output logic [$clog2(BITS)-1:0]  plane_idx,
    output logic [1:0]               color_sel,
    output logic [BITS-1:0]          dac_r,
    output logic [BITS-1:0]          dac_g,
    output logic [BITS-1:0]          dac_b,
    output logic                     dac_load,
    output logic                     led_on,
    output logic                     seq_start,
    output logic                     err_overrun
);
    localparam int IDX_W      = $clog2(BITS);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int SETTLE_RAW = (SETTLE_NS * CYC_PER_US) / 1000;
    localparam int PULSE_RAW  = (PULSE_NS * CYC_PER_US) / 1000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int PULSE_CYC  = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

    plane_pos_t pos;
    logic       accept;

    bpis_stepper #(.BITS(BITS)) u_step (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .color_en  (color_en),
        .pos       (pos),
        .seq_start (seq_start)
    );

    bpis_pulse_timer #(.SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .frame_ready(frame_ready),
        .color_ok   (color_on(pos.color, color_en)),
        .accept     (accept),
        .led_on     (led_on),
        .err_overrun(err_overrun)
    );

    bpis_dac_map #(.BITS(BITS)) u_dac (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .pos     (pos),
        .code_r  (dac_r),
        .code_g  (dac_g),
        .code_b  (dac_b),
        .dac_load(dac_load)
    );

    assign plane_idx = pos.plane[IDX_W-1:0];
    assign color_sel = pos.color;
endmodule

// File: rtl/bpis_checker.sv
module bpis_checker #(
    parameter int BITS       = 16,
    parameter int SETTLE_CYC = 225,
    parameter int PULSE_CYC  = 500
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    frame_tick,
    input logic [2:0]              color_en,
    input logic [$clog2(BITS)-1:0] plane_idx,
    input logic [1:0]              color_sel,
    input logic [BITS-1:0]         dac_r,
    input logic [BITS-1:0]         dac_g,
    input logic [BITS-1:0]         dac_b,
    input logic                    dac_load,
    input logic                    led_on,
    input logic                    seq_start,
    input logic                    err_overrun
);
    localparam logic [$clog2(BITS)-1:0] LAST = $clog2(BITS)'(BITS - 1);

    int since_load;
    int lit_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_load <= 0;
            lit_len    <= 0;
        end else begin
            if (dac_load)                   since_load <= 1;
            else if (since_load < 32'h3fff_ffff) since_load <= since_load + 1;
            lit_len <= led_on ? lit_len + 1 : 0;
        end
    end

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        frame_tick && plane_idx != LAST |=> plane_idx == $past(plane_idx) + 1'b1);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(plane_idx) && $stable(color_sel));
    assert_enabled_only_R3: assert property (@(posedge clk) disable iff (rst)
        led_on |-> color_en[color_sel]);
    assert_dac_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({|dac_r, |dac_g, |dac_b}) <= 1 && $onehot0(dac_r) && $onehot0(dac_g) && $onehot0(dac_b));
    assert_led_channel_R4: assert property (@(posedge clk) disable iff (rst)
        led_on |-> ((color_sel == 2'd0) ? |dac_r : (color_sel == 2'd1) ? |dac_g : |dac_b));
    assert_settle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(led_on) |-> since_load == SETTLE_CYC);
    assert_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(led_on) && !err_overrun |-> lit_len == PULSE_CYC);
    assert_single_load_R6: assert property (@(posedge clk) disable iff (rst)
        dac_load |=> !dac_load);
    assert_start_plane_R7: assert property (@(posedge clk) disable iff (rst)
        seq_start |-> plane_idx == '0);
    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        frame_tick && led_on |=> !led_on && err_overrun);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_overrun |=> err_overrun);
endmodule

bind bitplane_illum_seq bpis_checker #(
    .BITS      (BITS),
    .SETTLE_CYC(SETTLE_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .color_en   (color_en),
    .plane_idx  (plane_idx),
    .color_sel  (color_sel),
    .dac_r      (dac_r),
    .dac_g      (dac_g),
    .dac_b      (dac_b),
    .dac_load   (dac_load),
    .led_on     (led_on),
    .seq_start  (seq_start),
    .err_overrun(err_overrun)
);

// File: tb/bitplane_illum_seq_tb.sv
module bitplane_illum_seq_tb;
    localparam int BITS = 4;
    localparam int S    = 5;   // 100 ns at 50 MHz
    localparam int P    = 10;  // 200 ns at 50 MHz

    logic clk = 1'b0, rst = 1'b1, frame_tick = 1'b0, frame_ready = 1'b0;
    logic [2:0] color_en = 3'b111;
    logic [1:0] plane_idx;
    logic [1:0] color_sel;
    logic [BITS-1:0] dac_r, dac_g, dac_b;
    logic dac_load, led_on, seq_start, err_overrun;

    int checks = 0, errors = 0;
    int ec = 0, ep = 0;

    always #10 clk = ~clk;

    bitplane_illum_seq #(.BITS(BITS), .CLK_HZ(50_000_000), .SETTLE_NS(100), .PULSE_NS(200)) u_dut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .frame_ready(frame_ready),
        .color_en(color_en), .plane_idx(plane_idx), .color_sel(color_sel),
        .dac_r(dac_r), .dac_g(dac_g), .dac_b(dac_b), .dac_load(dac_load),
        .led_on(led_on), .seq_start(seq_start), .err_overrun(err_overrun));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int next_col(input int c, input logic [2:0] en);
        for (int k = 1; k <= 3; k++) if (en[(c + k) % 3]) return (c + k) % 3;
        return (c + 1) % 3;
    endfunction

    function automatic int low_col(input logic [2:0] en);
        for (int k = 0; k < 3; k++) if (en[k]) return k;
        return 0;
    endfunction

    function automatic int exp_code(input int ch);
        return (ch == ec) ? (1 << ep) : 0;
    endfunction

    task automatic do_tick(input string req);
        frame_tick = 1'b1;
        step();
        frame_tick = 1'b0;
        if (ep == BITS - 1) begin ep = 0; ec = next_col(ec, color_en); end
        else ep++;
        chk(plane_idx == ep, req, "plane", plane_idx, ep);
        chk(color_sel == ec, req, "color", color_sel, ec);
        chk(seq_start == (ep == 0 && ec == low_col(color_en)), "R7", "seq_start",
            seq_start, int'(ep == 0 && ec == low_col(color_en)));
    endtask

    task automatic do_pulse();
        int n, m;
        frame_ready = 1'b1;
        step();
        frame_ready = 1'b0;
        chk(dac_load == 1'b1, "R4", "dac_load", dac_load, 1);
        chk(dac_r == exp_code(0), "R4", "dac_r", dac_r, exp_code(0));
        chk(dac_g == exp_code(1), "R4", "dac_g", dac_g, exp_code(1));
        chk(dac_b == exp_code(2), "R4", "dac_b", dac_b, exp_code(2));
        n = 0;
        while (!led_on && n < S + P + 4) begin step(); n++; end
        chk(n == S, "R5", "settle cycles", n, S);
        m = 0;
        while (led_on && m < P + 4) begin step(); m++; end
        chk(m == P, "R5", "pulse cycles", m, P);
    endtask

    // no load and no pulse may follow; DAC stays as it was
    task automatic expect_reject(input string req);
        logic [BITS-1:0] r0, g0, b0;
        int seen;
        r0 = dac_r; g0 = dac_g; b0 = dac_b;
        seen = 0;
        frame_ready = 1'b1;
        step();
        frame_ready = 1'b0;
        for (int i = 0; i < S + P + 3; i++) begin
            if (dac_load || led_on) seen++;
            step();
        end
        chk(seen == 0, req, "activity on rejected ready", seen, 0);
        chk({dac_r, dac_g, dac_b} == {r0, g0, b0}, req, "dac changed", int'(dac_r), int'(r0));
    endtask

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk(plane_idx == 0 && color_sel == 0, "R1", "position", {color_sel, plane_idx}, 0);
        chk({led_on, dac_load, seq_start, err_overrun} == 4'b0, "R1", "flags",
            {led_on, dac_load, seq_start, err_overrun}, 0);
        chk({dac_r, dac_g, dac_b} == '0, "R1", "dac", int'({dac_r, dac_g, dac_b}), 0);
        rst = 1'b0;
        step();
        chk(plane_idx == 0 && color_sel == 0 && !led_on, "R1", "after release", {color_sel, plane_idx}, 0);

        // R2 R4 R5 R9: full cycle, every plane pulsed
        for (int k = 0; k < 3 * BITS; k++) begin
            do_pulse();
            step();
            do_tick("R2");
        end
        chk(ec == 0 && ep == 0 && color_sel == 0 && plane_idx == 0, "R9", "cycle closed",
            {color_sel, plane_idx}, 0);

        // R6: second ready in the same frame is ignored
        do_pulse();
        expect_reject("R6");
        do_tick("R2");

        // R6: ready while the current colour is disabled is ignored
        color_en = 3'b110;
        expect_reject("R6");
        // R3 R7: red masked, walk to green plane 0 which starts the cycle
        while (!(ec == 1 && ep == 0)) do_tick("R3");
        do_pulse();
        do_tick("R3");

        // R3: green masked, blue follows red
        color_en = 3'b101;
        for (int k = 0; k < 2 * BITS + 2; k++) do_tick("R3");
        do_pulse();

        // R3: nothing enabled, colour still rotates
        color_en = 3'b000;
        for (int k = 0; k < BITS + 1; k++) do_tick("R3");
        expect_reject("R6");
        color_en = 3'b111;
        do_tick("R2");

        // R8: tick during the pulse
        chk(err_overrun == 1'b0, "R8", "err before overrun", err_overrun, 0);
        frame_ready = 1'b1;
        step();
        frame_ready = 1'b0;
        repeat (S + 2) step();
        chk(led_on == 1'b1, "R8", "lit before tick", led_on, 1);
        do_tick("R2");
        chk(led_on == 1'b0, "R8", "led after tick", led_on, 0);
        chk(err_overrun == 1'b1, "R8", "err set", err_overrun, 1);
        repeat (4) step();
        do_tick("R2");
        chk(err_overrun == 1'b1, "R8", "err sticky", err_overrun, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule